// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divide-Ratio Generator

This block supplies the feedback divide ratio for a fractional-N PLL. The ratio is a 32-bit fixed-point number with 8 integer bits and 24 fraction bits. Its nominal value is the VCO frequency over the PFD frequency. The block moves that ratio along a symmetric triangle, so the synthesized clock sweeps in frequency and its spectral energy is spread out. Each reference tick advances the triangle by one update. The output feeds a sigma-delta or fractional divider directly.

Three modes are available. With spread disabled the output stays at the nominal ratio. Down spread only ever lowers the ratio from the nominal value. Center spread raises the whole sweep by half of the deviation, so the average sits at the nominal value. A common setting is about 0.5% down spread with a period of a few tens of reference ticks. The block takes a new mode, amount, nominal ratio and period only when a new triangle period begins. A change made partway through a sweep therefore never produces an unsymmetric cycle.

Top module: `ssc_ratio_mod`

## Requirements
- R1: After synchronous reset the output equals the nominal ratio sampled during reset, the mode acts as off, and the next tick starts a new period on the falling half.
- R2: Mode encoding on `mode`: 2'b00 and 2'b11 are off, 2'b01 is down spread, 2'b10 is center spread. With off latched, the output equals the latched nominal ratio on every cycle, whatever `spread_amt` is.
- R3: In down mode the output is nominal minus the accumulated offset. The total deviation is (nominal × `spread_amt`) >> 16, so `spread_amt` is a fraction in units of 2^-16. The step is deviation / half, with integer division. The output never exceeds the nominal ratio.
- R4: Each tick in the first half of a period increases the offset by one step, which lowers the ratio. Each tick in the second half decreases it by one step. A full period lasts 2 × half ticks.
- R5: The offset peaks at exactly half × step and returns exactly to zero at the end of every period, so there is no drift.
- R6: In center mode the output is nominal + (deviation >> 1) − offset.
- R7: `mode`, `spread_amt`, `nom_ratio` and `period` are sampled only on the tick that starts a period. Changes made partway through a period leave that period unaltered.
- R8: half = `period` >> 1, with odd periods rounded down. A `period` of 0 or 1 gives half = 1.
- R9: The output changes only in the cycle after a tick. It holds steady while `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference update strobe, one cycle per update |
| nom_ratio | input | 32 | Nominal ratio, 8.24 fixed point |
| spread_amt | input | 16 | Total spread as a fraction, units of 2^-16 |
| mode | input | 2 | 00 off, 01 down, 10 center, 11 off |
| period | input | 16 | Full triangle period in ticks |
| ratio_o | output | 32 | Instantaneous divide ratio, 8.24 fixed point |

## Verification
The bench runs full down and center periods and expects the ratio to land exactly on nominal at each period end. A design that reversed one tick late, or let rounding pile up, would drift away from nominal after a few periods. It changes the mode and the amount partway through a sweep; a design that took them at once would jump to a new slope mid-triangle. It uses periods of 0, 1 and 7 to catch half-period rounding and zero-length halves. It also leaves gaps with no tick, which would expose a design that advances on every clock.

// File: rtl/ssc_ratio_mod.sv
module ssc_ratio_mod #(
  parameter int RW = 32,
  parameter int AW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [RW-1:0] nom_ratio,
  input  logic [AW-1:0] spread_amt,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] period,
  output logic [RW-1:0] ratio_o
);
  localparam logic [1:0] M_DOWN = 2'b01;
  localparam logic [1:0] M_CTR  = 2'b10;

  logic [RW-1:0]    cfg_nom, cfg_dev, cfg_step, acc;
  logic [1:0]       cfg_mode;
  logic [PW-1:0]    cfg_half, cnt;
  logic             rising;

  logic [RW+AW-1:0] prod;
  logic [RW-1:0]    dev_in, step_in, step_eff;
  logic [PW-1:0]    half_in, half_eff;
  logic             start, last;

  assign prod     = nom_ratio * spread_amt;
  assign dev_in   = RW'(prod >> AW);
  assign half_in  = ((period >> 1) == '0) ? PW'(1) : (period >> 1);
  assign step_in  = dev_in / {{(RW-PW){1'b0}}, half_in};

  assign start    = tick && !rising && (cnt == '0);
  assign half_eff = start ? half_in : cfg_half;
  assign step_eff = start ? step_in : cfg_step;
  assign last     = (cnt + 1'b1) == half_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_nom  <= nom_ratio;
      cfg_mode <= 2'b00;
      cfg_dev  <= '0;
      cfg_step <= '0;
      cfg_half <= PW'(1);
      acc      <= '0;
      cnt      <= '0;
      rising   <= 1'b0;
    end else if (tick) begin
      if (start) begin
        cfg_nom  <= nom_ratio;
        cfg_mode <= mode;
        cfg_dev  <= dev_in;
        cfg_step <= step_in;
        cfg_half <= half_in;
      end
      acc <= rising ? acc - step_eff : acc + step_eff;
      if (last) begin
        cnt    <= '0;
        rising <= !rising;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_mode)
      M_DOWN:  ratio_o = cfg_nom - acc;
      M_CTR:   ratio_o = cfg_nom + (cfg_dev >> 1) - acc;
      default: ratio_o = cfg_nom;
    endcase
  end

  logic [RW+PW-1:0] peak;
  assign peak = cfg_step * cfg_half;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ratio_o)); // R9
  AST_CFG_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    (tick && !start) |=> ($stable(cfg_mode) && $stable(cfg_dev) && $stable(cfg_nom))); // R7
  AST_ZERO_AT_START: assert property (@(posedge clk) disable iff (rst)
    start |-> (acc == '0)); // R5
  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (rst)
    {{PW{1'b0}}, acc} <= peak); // R5
  AST_FALL_HALF: assert property (@(posedge clk) disable iff (rst)
    (tick && !rising) |=> (acc >= $past(acc))); // R4
  AST_DOWN_BELOW: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == M_DOWN) |-> (ratio_o <= cfg_nom)); // R3
endmodule

// File: tb/ssc_ratio_mod_tb.sv
module ssc_ratio_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [31:0] nom_ratio = 32'h2800_0000;
  logic [15:0] spread_amt = 16'd0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] period = 16'd20;
  logic [31:0] ratio_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] b_nom;
  logic [1:0]  b_mode;
  longint      b_dev, b_step, b_half, b_k, b_acc;

  always #4 clk = ~clk;

  ssc_ratio_mod dut_i (
    .clk(clk), .rst(rst), .tick(tick), .nom_ratio(nom_ratio),
    .spread_amt(spread_amt), .mode(mode), .period(period), .ratio_o(ratio_o)
  );

  function automatic logic [31:0] model_out();
    longint v;
    case (b_mode)
      2'b01:   v = longint'(b_nom) - b_acc;
      2'b10:   v = longint'(b_nom) + (b_dev >> 1) - b_acc;
      default: v = longint'(b_nom);
    endcase
    return v[31:0];
  endfunction

  task automatic model_tick();
    if (b_k == 0) begin
      b_nom  = nom_ratio;
      b_mode = mode;
      b_half = longint'(period) >> 1;
      if (b_half == 0) b_half = 1;
      b_dev  = (longint'(nom_ratio) * longint'(spread_amt)) >> 16;
      b_step = b_dev / b_half;
    end
    b_k++;
    b_acc = (b_k <= b_half) ? b_k * b_step : (2 * b_half - b_k) * b_step;
    if (b_k == 2 * b_half) b_k = 0;
  endtask

  task automatic cyc(input logic t, input string tag);
    @(negedge clk);
    tick = t;
    @(posedge clk);
    #1;
    tick = 1'b0;
    if (t) model_tick();
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    b_nom = nom_ratio; b_mode = 2'b00; b_k = 0; b_acc = 0; b_dev = 0; b_step = 0; b_half = 1;
    exp_q.push_back(b_nom);
    tag_q.push_back("R1");
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (ratio_o !== e) begin
        failures++;
        $display("FAIL %s ratio got=%h exp=%h", tg, ratio_o, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(1'b0, "R1");
    // R2: off mode with a nonzero amount keeps the ratio flat
    spread_amt = 16'd328; mode = 2'b00; period = 16'd20;
    run_ticks(20, "R2");
    mode = 2'b11;
    run_ticks(20, "R2");
    // R3 R4: down spread, two full periods
    mode = 2'b01;
    run_ticks(19, "R4");
    cyc(1'b1, "R5");
    run_ticks(19, "R3");
    cyc(1'b1, "R5");
    // R9: idle gaps mid-sweep
    run_ticks(5, "R4");
    for (int i = 0; i < 4; i++) cyc(1'b0, "R9");
    run_ticks(4, "R4");
    cyc(1'b0, "R9");
    run_ticks(11, "R5");
    // R6: center spread, larger amount
    mode = 2'b10; spread_amt = 16'd1311;
    run_ticks(40, "R6");
    // R7: changes mid-period wait for the next period
    mode = 2'b01; spread_amt = 16'd200; period = 16'd12;
    run_ticks(6, "R7");
    mode = 2'b10; spread_amt = 16'd3000; nom_ratio = 32'h3180_0000; period = 16'd30;
    run_ticks(6, "R7");
    run_ticks(30, "R7");
    // R8: odd, one and zero periods
    mode = 2'b01; period = 16'd7;
    run_ticks(12, "R8");
    period = 16'd1;
    run_ticks(4, "R8");
    period = 16'd0; mode = 2'b10;
    run_ticks(4, "R8");
    // R1: reset mid-sweep returns to nominal
    mode = 2'b01; period = 16'd20;
    run_ticks(7, "R3");
    nom_ratio = 32'h2000_0000;
    do_reset();
    run_ticks(3, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule